// File: doc/BRIEF.md
# Fixed-Latency Load Return Buffer

This block sits between the load issue stage of a statically scheduled pipeline and a memory whose response time varies. Software writes a latency value N into a small register. From then on, every load accepted by the block is handed to the pipeline's writeback port exactly N cycles after it was accepted. The exception is a load whose data is late. The compiler can then schedule consumers of a load as if memory always took N cycles.

Each accepted load takes a slot holding its tag, destination register number, a data-present flag and a countdown. Memory answers with a tag and data, in any order. A response that comes before the deadline is parked in the slot's data storage until the countdown expires. A response that comes in the very cycle of the deadline is forwarded straight through. A deadline with no data raises the stall output, and all countdowns hold their values until the data shows up. The stall output is also raised when every slot is busy, and issue is then refused.

Top module: `load_latency_equalizer`

## Requirements
- R1: After synchronous reset, `stall` and `wb_valid` are low, no slot is occupied, and the latency register holds the parameter `LAT_RST` (default 4).
- R2: A load accepted on a rising edge (with `iss_valid` high and `stall` low) is written back on the N-th rising edge after that one, so `wb_valid` is high in the cycle that starts there. This holds when its data is present by the deadline and no stall intervenes. N is the latency value in effect when the load was accepted.
- R3: A response that arrives before its load's deadline is held, and the writeback carries that load's tag, its destination and the response data.
- R4: When a load's countdown has expired, its data is not held, and no matching response is present in that cycle, `stall` is high. A matching response in the deadline cycle is forwarded to writeback on the next edge without a stall.
- R5: While `stall` is high because of a late or colliding load, no countdown advances, so every load in flight is delayed by the same number of cycles.
- R6: When all `SLOTS` slots are occupied, `stall` is high and an issue request is ignored; that load is never written back.
- R7: A latency write of 0 gives a latency of 1. A write takes effect for loads accepted after the write edge, so a load accepted on the same edge as the write uses the old value.
- R8: A response whose tag matches no in-flight load still awaiting data changes nothing.
- R9: New loads take the lowest-numbered free slot. If several loads reach their deadline in the same cycle, `stall` is high, and one is written back per cycle, lowest slot first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_we | input | 1 | Write strobe for the latency register |
| lat_wdata | input | 5 | New latency value in cycles (0 means 1) |
| iss_valid | input | 1 | A load is being issued this cycle |
| iss_tag | input | TAG_W | Tag of the issued load |
| iss_dest | input | DEST_W | Destination register of the issued load |
| rsp_valid | input | 1 | Memory response present this cycle |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_data | input | DATA_W | Response data |
| stall | output | 1 | Pipeline hold: buffer full, a late load, or a deadline collision |
| wb_valid | output | 1 | Writeback valid (registered) |
| wb_tag | output | TAG_W | Tag of the load being written back |
| wb_dest | output | DEST_W | Destination register of the writeback |
| wb_data | output | DATA_W | Load data being written back |

## Verification
The hardest state to reach from the ports is a deadline collision. Two loads can only expire in the same cycle if the latency register is lowered between their issues, and the later one's data must also be present in time. A directed case sets a long latency, issues a load, rewrites the latency to a short value and issues a second load so that both deadlines meet. It then checks the writeback order and the one-cycle stall. Random traffic with frequent latency rewrites, late and bogus responses revisits such collisions while a cycle model in the bench tracks every slot.

// File: rtl/lle_pkg.sv
package lle_pkg;

  localparam int LAT_W = 5;

  typedef logic [LAT_W-1:0] lat_t;

  // A programmed latency of zero behaves as one cycle.
  function automatic lat_t lat_floor1(input lat_t v);
    return (v == '0) ? lat_t'(1) : v;
  endfunction

endpackage

// File: rtl/lle_pick.sv
// Lowest-index-first picker: one-hot grant plus "anything requested".
module lle_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lle_slot.sv
// One outstanding load: identity, data-present flag and deadline countdown.
module lle_slot
  import lle_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DEST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [DEST_W-1:0] alloc_dest,
  input  lat_t              alloc_cnt,
  input  logic              fill,
  input  logic              retire,
  input  logic              hold,
  output logic              valid,
  output logic              have,
  output logic              due,
  output logic [TAG_W-1:0]  tag,
  output logic [DEST_W-1:0] dest
);

  logic              valid_q;
  logic              have_q;
  lat_t              cnt_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DEST_W-1:0] dest_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      have_q  <= 1'b0;
      cnt_q   <= '0;
      tag_q   <= '0;
      dest_q  <= '0;
    end else if (alloc) begin
      valid_q <= 1'b1;
      have_q  <= 1'b0;
      cnt_q   <= alloc_cnt;
      tag_q   <= alloc_tag;
      dest_q  <= alloc_dest;
    end else begin
      if (retire) begin
        valid_q <= 1'b0;
        have_q  <= 1'b0;
      end else if (fill) begin
        have_q <= 1'b1;
      end
      if (valid_q && !hold && cnt_q != '0) begin
        cnt_q <= cnt_q - lat_t'(1);
      end
    end
  end

  assign valid = valid_q;
  assign have  = have_q;
  assign due   = valid_q && (cnt_q == '0);
  assign tag   = tag_q;
  assign dest  = dest_q;

  // R5: a held pipeline freezes this slot's countdown.
  p_cnt_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && hold) |=> (cnt_q == $past(cnt_q)));

  // R3: parked data stays until the slot is written back.
  p_data_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (have_q && !retire) |=> have_q);

  // R2: the top only retires a slot whose countdown has run out.
  p_retire_due_r2: assert property (@(posedge clk) disable iff (rst)
    retire |-> (valid_q && cnt_q == '0));

endmodule

// File: rtl/load_latency_equalizer.sv
module load_latency_equalizer
  import lle_pkg::*;
#(
  parameter int SLOTS   = 8,
  parameter int TAG_W   = 4,
  parameter int DEST_W  = 6,
  parameter int DATA_W  = 32,
  parameter int LAT_RST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lat_we,
  input  logic [LAT_W-1:0]  lat_wdata,
  input  logic              iss_valid,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [DEST_W-1:0] iss_dest,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              stall,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DEST_W-1:0] wb_dest,
  output logic [DATA_W-1:0] wb_data
);

  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // Latency register: sampled by issue before a same-edge write lands.
  lat_t lat_q;
  lat_t alloc_cnt;

  always_ff @(posedge clk) begin
    if (rst)         lat_q <= lat_t'(LAT_RST);
    else if (lat_we) lat_q <= lat_wdata;
  end

  assign alloc_cnt = lat_floor1(lat_q) - lat_t'(1);

  // Slot state vectors.
  logic [SLOTS-1:0]  s_valid, s_have, s_due;
  logic [TAG_W-1:0]  s_tag  [SLOTS];
  logic [DEST_W-1:0] s_dest [SLOTS];

  logic [SLOTS-1:0] free_gnt, fill_req, fill_gnt, ret_req, ret_gnt;
  logic             free_any, fill_any, ret_any;
  logic [IDX_W-1:0] fill_idx, ret_idx;
  logic             late, multi, hold, full, accept;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      fill_req[i] = rsp_valid && s_valid[i] && !s_have[i] && (s_tag[i] == rsp_tag);
    end
  end

  lle_pick #(.N(SLOTS)) u_free_pick (.req(~s_valid), .gnt(free_gnt), .any(free_any));
  lle_pick #(.N(SLOTS)) u_fill_pick (.req(fill_req), .gnt(fill_gnt), .any(fill_any));

  // A due slot is ready if its data is parked or arrives right now.
  assign ret_req = s_due & (s_have | fill_gnt);

  lle_pick #(.N(SLOTS)) u_ret_pick (.req(ret_req), .gnt(ret_gnt), .any(ret_any));

  always_comb begin
    fill_idx = '0;
    ret_idx  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (fill_gnt[i]) fill_idx = fill_idx | IDX_W'(i);
      if (ret_gnt[i])  ret_idx  = ret_idx  | IDX_W'(i);
    end
  end

  assign late   = |(s_due & ~s_have & ~fill_gnt);
  assign multi  = ($countones(s_due) > 1);
  assign hold   = late || multi;
  assign full   = !free_any;
  assign stall  = full || hold;
  assign accept = iss_valid && !stall;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      lle_slot #(.TAG_W(TAG_W), .DEST_W(DEST_W)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .alloc      (accept && free_gnt[g]),
        .alloc_tag  (iss_tag),
        .alloc_dest (iss_dest),
        .alloc_cnt  (alloc_cnt),
        .fill       (fill_gnt[g]),
        .retire     (ret_gnt[g]),
        .hold       (hold),
        .valid      (s_valid[g]),
        .have       (s_have[g]),
        .due        (s_due[g]),
        .tag        (s_tag[g]),
        .dest       (s_dest[g])
      );
    end
  endgenerate

  // Parked response data: one write, one read per cycle, no reset.
  logic [DATA_W-1:0] park_mem [SLOTS];

  always_ff @(posedge clk) begin
    if (fill_any) park_mem[fill_idx] <= rsp_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_tag   <= '0;
      wb_dest  <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= ret_any;
      if (ret_any) begin
        wb_tag  <= s_tag[ret_idx];
        wb_dest <= s_dest[ret_idx];
        wb_data <= s_have[ret_idx] ? park_mem[ret_idx] : rsp_data;
      end
    end
  end

  // R6: no slot is taken while the pipeline is held.
  p_issue_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($countones(s_valid) <= $past($countones(s_valid))));

endmodule

// File: tb/load_latency_equalizer_tb.sv
module load_latency_equalizer_tb;
  import lle_pkg::*;

  localparam int SLOTS  = 8;
  localparam int TAG_W  = 4;
  localparam int DEST_W = 6;
  localparam int DATA_W = 32;
  localparam int NTAG   = 1 << TAG_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              lat_we = 1'b0;
  logic [LAT_W-1:0]  lat_wdata = '0;
  logic              iss_valid = 1'b0;
  logic [TAG_W-1:0]  iss_tag = '0;
  logic [DEST_W-1:0] iss_dest = '0;
  logic              rsp_valid = 1'b0;
  logic [TAG_W-1:0]  rsp_tag = '0;
  logic [DATA_W-1:0] rsp_data = '0;
  logic              stall, wb_valid;
  logic [TAG_W-1:0]  wb_tag;
  logic [DEST_W-1:0] wb_dest;
  logic [DATA_W-1:0] wb_data;

  load_latency_equalizer #(.SLOTS(SLOTS), .TAG_W(TAG_W), .DEST_W(DEST_W),
                           .DATA_W(DATA_W), .LAT_RST(4)) u_dut (
    .clk(clk), .rst(rst), .lat_we(lat_we), .lat_wdata(lat_wdata),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_dest(iss_dest),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .stall(stall), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wb_dest(wb_dest), .wb_data(wb_data));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit last_stall;
  int stall_cnt = 0;

  // Bench model of the requirements.
  bit                m_v    [SLOTS];
  bit                m_have [SLOTS];
  int                m_cnt  [SLOTS];
  logic [TAG_W-1:0]  m_tag  [SLOTS];
  logic [DEST_W-1:0] m_dest [SLOTS];
  logic [DATA_W-1:0] m_data [SLOTS];
  int                m_lat = 4;
  bit                e_wv = 1'b0;
  logic [TAG_W-1:0]  e_wt;
  logic [DEST_W-1:0] e_wd;
  logic [DATA_W-1:0] e_wdata;
  int                wb_at  [NTAG];
  int                iss_at [NTAG];

  function automatic int eff_lat(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit tag_busy(input int t);
    for (int i = 0; i < SLOTS; i++)
      if (m_v[i] && m_tag[i] == TAG_W'(t)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_marks();
    for (int t = 0; t < NTAG; t++) begin
      wb_at[t]  = -1;
      iss_at[t] = -1;
    end
  endtask

  // One cycle: drive at the falling edge, compare outputs, advance the model.
  task automatic step(input bit iv = 0, input int itag = 0, input int idest = 0,
                      input bit rv = 0, input int rtag = 0,
                      input logic [DATA_W-1:0] rdata = '0,
                      input bit lw = 0, input int lwd = 0);
    int f, ret, ndue, alloc;
    bit late, hold, full, st;
    string lbl;
    @(negedge clk);
    cyc++;
    iss_valid = iv;  iss_tag = TAG_W'(itag);  iss_dest = DEST_W'(idest);
    rsp_valid = rv;  rsp_tag = TAG_W'(rtag);  rsp_data = rdata;
    lat_we = lw;     lat_wdata = LAT_W'(lwd);
    #1;
    f = -1;
    if (rv)
      for (int i = 0; i < SLOTS; i++)
        if (f < 0 && m_v[i] && !m_have[i] && m_tag[i] == TAG_W'(rtag)) f = i;
    ndue = 0; late = 1'b0; full = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      if (!m_v[i]) full = 1'b0;
      if (m_v[i] && m_cnt[i] == 0) begin
        ndue++;
        if (!m_have[i] && i != f) late = 1'b1;
      end
    end
    hold = late || (ndue > 1);
    st   = full || hold;
    lbl  = full ? "R6" : ((ndue > 1) ? "R9" : "R4");
    chk(stall === st, lbl, "stall", longint'(stall), longint'(st));
    chk(wb_valid === e_wv, "R2", "wb_valid", longint'(wb_valid), longint'(e_wv));
    if (e_wv && wb_valid)
      chk(wb_tag === e_wt && wb_dest === e_wd && wb_data === e_wdata, "R3",
          "writeback tag/dest/data", {wb_tag, wb_dest, wb_data}, {e_wt, e_wd, e_wdata});
    if (wb_valid) wb_at[wb_tag] = cyc;
    last_stall = stall;
    if (stall) stall_cnt++;
    // model edge
    alloc = -1;
    for (int i = 0; i < SLOTS; i++) if (alloc < 0 && !m_v[i]) alloc = i;
    ret = -1;
    for (int i = 0; i < SLOTS; i++)
      if (ret < 0 && m_v[i] && m_cnt[i] == 0 && (m_have[i] || i == f)) ret = i;
    e_wv = (ret >= 0);
    if (ret >= 0) begin
      e_wt = m_tag[ret]; e_wd = m_dest[ret];
      e_wdata = m_have[ret] ? m_data[ret] : rdata;
      m_v[ret] = 1'b0; m_have[ret] = 1'b0;
    end
    if (f >= 0 && f != ret) begin m_have[f] = 1'b1; m_data[f] = rdata; end
    if (!hold)
      for (int i = 0; i < SLOTS; i++) if (m_v[i] && m_cnt[i] > 0) m_cnt[i]--;
    if (iv && !st) begin
      m_v[alloc] = 1'b1; m_have[alloc] = 1'b0;
      m_cnt[alloc] = eff_lat(m_lat) - 1;
      m_tag[alloc] = TAG_W'(itag); m_dest[alloc] = DEST_W'(idest);
      iss_at[itag] = cyc;
    end
    if (lw) m_lat = lwd;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(20 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0, s0;
    void'($urandom(32'h1d5eed));
    for (int i = 0; i < SLOTS; i++) begin m_v[i] = 0; m_have[i] = 0; m_cnt[i] = 0; end
    clear_marks();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: quiet outputs out of reset.
    step();
    chk(!last_stall && !wb_valid, "R1", "reset outputs", {stall, wb_valid}, 0);

    // R2/R3 with the reset latency of 4; writeback N+1 steps after the issue step.
    step(1, 1, 5);
    step(0, 0, 0, 1, 1, 32'hCAFE_0001);
    idle(7);
    chk(wb_at[1] - iss_at[1] == 5, "R1", "reset latency", wb_at[1] - iss_at[1], 5);
    chk(wb_at[1] - iss_at[1] == 5, "R2", "on-time writeback", wb_at[1] - iss_at[1], 5);

    // R7: zero means one; the same-edge write leaves the issuing load on the old value.
    step(0, 0, 0, 0, 0, '0, 1, 0);
    step(1, 2, 7);
    step(0, 0, 0, 1, 2, 32'h0000_0222);
    idle(3);
    chk(wb_at[2] - iss_at[2] == 2, "R7", "latency 0 as 1", wb_at[2] - iss_at[2], 2);
    step(1, 3, 9, 0, 0, '0, 1, 3);
    step(0, 0, 0, 1, 3, 32'h0000_0333);
    idle(3);
    chk(wb_at[3] - iss_at[3] == 2, "R7", "same-edge write uses old", wb_at[3] - iss_at[3], 2);
    step(1, 4, 1);
    step(0, 0, 0, 1, 4, 32'h0000_0444);
    idle(5);
    chk(wb_at[4] - iss_at[4] == 4, "R7", "new latency 3", wb_at[4] - iss_at[4], 4);

    // R4/R5: late load A stalls three cycles; younger B is delayed equally.
    clear_marks();
    c0 = cyc + 1;
    step(1, 5, 2);
    step(1, 6, 3);
    step(0, 0, 0, 1, 6, 32'h0000_0666);
    s0 = stall_cnt;
    for (int k = 0; k < 3; k++) step();
    step(0, 0, 0, 1, 5, 32'h0000_0555);
    idle(4);
    chk(stall_cnt - s0 == 3, "R4", "late stall cycles", stall_cnt - s0, 3);
    chk(wb_at[5] - c0 == 7, "R4", "late load writeback", wb_at[5] - c0, 7);
    chk(wb_at[6] - iss_at[6] == 7, "R5", "frozen countdown delay", wb_at[6] - iss_at[6], 7);

    // R8: a bogus tag does not supply the waiting load.
    clear_marks();
    step(0, 0, 0, 0, 0, '0, 1, 4);
    step(1, 10, 4);
    step(0, 0, 0, 1, 11, 32'h0BAD_0BAD);
    idle(2);
    step();
    chk(last_stall == 1'b1, "R8", "stall after bogus tag", last_stall, 1);
    step(0, 0, 0, 1, 10, 32'h0000_0AAA);
    idle(3);

    // R6: fill every slot, the ninth issue is refused.
    clear_marks();
    step(0, 0, 0, 0, 0, '0, 1, 12);
    for (int k = 0; k < SLOTS; k++) step(1, k, k);
    step(1, 8, 8);
    chk(last_stall == 1'b1, "R6", "full stall", last_stall, 1);
    for (int k = 0; k < SLOTS; k++) step(0, 0, 0, 1, k, 32'h6000_0000 + k);
    idle(16);
    chk(wb_at[8] == -1, "R6", "refused load never written back", wb_at[8], -1);

    // R9: two deadlines meet; lowest slot first, one stall cycle.
    clear_marks();
    step(0, 0, 0, 0, 0, '0, 1, 5);
    c0 = cyc + 1;
    step(1, 12, 12);
    step(0, 0, 0, 1, 12, 32'h0000_0C0C);
    step(0, 0, 0, 0, 0, '0, 1, 2);
    step(1, 13, 13);
    step(0, 0, 0, 1, 13, 32'h0000_0D0D);
    step();
    chk(last_stall == 1'b1, "R9", "collision stall", last_stall, 1);
    idle(3);
    chk(wb_at[12] == c0 + 6, "R9", "first of collision", wb_at[12], c0 + 6);
    chk(wb_at[13] == c0 + 7, "R9", "second of collision", wb_at[13], c0 + 7);

    // Random traffic against the model.
    for (int n = 0; n < 4000; n++) begin
      bit iv, rv, lw;
      int it, rt, lwd, pick;
      iv = ($urandom_range(0, 99) < 45);
      it = $urandom_range(0, NTAG - 1);
      for (int k = 0; k < NTAG && tag_busy(it); k++) it = (it + 1) % NTAG;
      rv = 1'b0; rt = 0;
      if ($urandom_range(0, 99) < 50) begin
        pick = $urandom_range(0, SLOTS - 1);
        for (int k = 0; k < SLOTS; k++) begin
          int j;
          j = (pick + k) % SLOTS;
          if (!rv && m_v[j] && !m_have[j]) begin rv = 1'b1; rt = m_tag[j]; end
        end
      end else if ($urandom_range(0, 99) < 8) begin
        rt = $urandom_range(0, NTAG - 1);
        rv = !tag_busy(rt);
      end
      lw  = ($urandom_range(0, 99) < 4);
      lwd = $urandom_range(0, 7);
      step(iv, it, $urandom_range(0, 63), rv, rt, $urandom, lw, lwd);
    end

    // Drain: answer everything still waiting.
    for (int n = 0; n < 300; n++) begin
      bit rv;
      int rt;
      rv = 1'b0; rt = 0;
      for (int j = 0; j < SLOTS; j++)
        if (!rv && m_v[j] && !m_have[j]) begin rv = 1'b1; rt = m_tag[j]; end
      step(0, 0, 0, rv, rt, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule